// File: doc/BRIEF.md
# SD Transfer Stop Sequencer

This block decides how and when a block data transfer on an SD, MMC or SDIO host comes to an end. Software starts a transfer with a one-cycle `start` pulse carrying the card kind, the direction, the length class (single block, counted multi-block or open-ended multi-block), a programmed block count, an automatic-stop enable and a read-wait capability flag. From then on the data path reports each finished block with a `blk_done` strobe. Software may also pulse `stop_req` (end the transfer early) or `gap_req` (park the transfer at the next block gap).

A stop never reaches the card in the middle of a block. Every request is held until the next block boundary. At that boundary the sequencer either ends the transfer on its own or hands a command to the command-line serializer through a `cmd_valid`/`cmd_ready` handshake. The command index is 12 for memory cards and 52 for SDIO cards. Completion is reported by a one-cycle `xfer_done` pulse. `gap_hold` shows that the transfer is parked at a block gap.

All outputs come from registers and change on the clock edge after the event that causes them. A reset is synchronous and active high.

Top module: `transfer_stop_seq`

## Requirements
- R1: A single-block transfer (`xfer_mode` 2'b00) ends at its first `blk_done`: `xfer_done` is high for the one cycle after that boundary, and no command is requested.
- R2: On a memory card (`card_sdio`=0), a stop request in a multi-block transfer that is not at its final block raises `cmd_valid` with `cmd_index`=12 in the cycle after the next boundary. `xfer_done` follows in the cycle after the handshake is accepted (`cmd_valid`&&`cmd_ready`).
- R3: On an SDIO card (`card_sdio`=1), the same early stop uses `cmd_index`=52. Completion follows the same handshake timing as R2.
- R4: A counted transfer (`xfer_mode` 2'b01) on a memory card with `auto_stop` set issues command 12 by itself after its final block, then completes after the handshake. With `auto_stop` clear, or on an SDIO card, the transfer completes in the cycle after the final block and requests no command.
- R5: An open-ended transfer (`xfer_mode` 2'b10 or 2'b11) never completes from block boundaries alone. It ends only through a stop or a gap request.
- R6: A stop or gap request that arrives mid-block is held. No command and no `gap_hold` change appear before the next `blk_done`. Once raised, `cmd_valid` and `cmd_index` stay unchanged until `cmd_ready` is seen.
- R7: A gap request on anything other than an SDIO read raises `gap_hold` and pulses `xfer_done` in the cycle after the next boundary, with no command. `gap_hold` stays high until the next accepted `start`.
- R8: A gap request on an SDIO read (`card_sdio`=1, `dir_read`=1) issues command 52 after the boundary, whatever `read_wait_ok` says. `gap_hold` rises together with `cmd_valid` only if `read_wait_ok` was set at `start`. `xfer_done` follows the handshake.
- R9: A stop or gap request while no transfer is active is ignored. A `start` during an active transfer is also ignored.
- R10: At a boundary, the natural end of a single or final counted block takes priority over a pending stop, and a pending stop takes priority over a pending gap request.
- R11: `xfer_done` lasts exactly one cycle and is never high in the same cycle as `cmd_valid`.
- R12: After reset, `cmd_valid`, `cmd_index`, `gap_hold` and `xfer_done` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle transfer launch, accepted only when idle |
| card_sdio | input | 1 | 1 = SDIO card, 0 = memory card |
| dir_read | input | 1 | 1 = read, 0 = write |
| xfer_mode | input | 2 | 00 single, 01 counted, 10/11 open-ended |
| blk_count | input | CNT_W | Programmed block count for counted transfers (0 treated as 1) |
| auto_stop | input | 1 | Automatic stop enable for counted transfers |
| read_wait_ok | input | 1 | Card supports read-wait pausing |
| stop_req | input | 1 | Software request to end the transfer early |
| gap_req | input | 1 | Software request to stop at a block gap |
| blk_done | input | 1 | Block-boundary strobe from the data path |
| cmd_ready | input | 1 | Command serializer accepts the request |
| cmd_valid | output | 1 | Stop/abort command request |
| cmd_index | output | IDX_W | Command index, 12 or 52 |
| gap_hold | output | 1 | Transfer parked at a block gap |
| xfer_done | output | 1 | One-cycle transfer-complete pulse |

## Verification
A held request that was lost or cleared too early shows up as a missing `cmd_valid` one cycle after the boundary that should have used it. A request that is latched when it should be ignored shows up as a spurious command or completion after a later boundary. A block counter that is off by one moves `xfer_done` or the automatic command 12 by a whole block period, so it appears at the first boundary where the reference expects the final block. A wrong selection of card kind or priority appears at once in `cmd_index`, or as a command where a plain completion was due. The reference model compares all four outputs on every cycle, so each such fault appears within one cycle of the boundary that exposes it.

// File: rtl/tss_pkg.sv
package tss_pkg;

  typedef enum logic [1:0] {
    LEN_SINGLE  = 2'b00,
    LEN_COUNTED = 2'b01,
    LEN_OPEN    = 2'b10,
    LEN_OPEN_B  = 2'b11
  } len_class_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_XFER  = 2'b01,
    ST_ISSUE = 2'b10
  } seq_state_e;

  typedef enum logic [1:0] {
    ACT_NONE     = 2'b00,
    ACT_FINISH   = 2'b01,
    ACT_COMMAND  = 2'b10,
    ACT_PARK_END = 2'b11
  } bound_act_e;

  typedef struct packed {
    logic       sdio;
    logic       rd;
    len_class_e len;
    logic       autostop;
    logic       rwait;
  } xfer_cfg_t;

  localparam int unsigned MEM_STOP_IDX = 12;
  localparam int unsigned IO_ABORT_IDX = 52;

endpackage

// File: rtl/tss_req_latch.sv
module tss_req_latch (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic req,
  input  logic clear,
  output logic pending
);

  logic held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
    end else if (clear) begin
      held_q <= 1'b0;
    end else if (enable && req) begin
      held_q <= 1'b1;
    end
  end

  // a request arriving on the boundary cycle itself is honoured at that boundary
  assign pending = held_q | (enable & req);

endmodule

// File: rtl/tss_blk_counter.sv
module tss_blk_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             at_last
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= ONE;
    end else if (load) begin
      remain_q <= (load_val == '0) ? ONE : load_val;
    end else if (dec && (remain_q > ONE)) begin
      remain_q <= remain_q - ONE;
    end
  end

  assign at_last = (remain_q <= ONE);

endmodule

// File: rtl/tss_stop_select.sv
module tss_stop_select
  import tss_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  xfer_cfg_t        cfg,
  input  logic             cnt_last,
  input  logic             stop_pend,
  input  logic             gap_pend,
  output bound_act_e       act,
  output logic [IDX_W-1:0] idx,
  output logic             set_hold
);

  localparam logic [IDX_W-1:0] IDX_MEM = IDX_W'(MEM_STOP_IDX);
  localparam logic [IDX_W-1:0] IDX_IO  = IDX_W'(IO_ABORT_IDX);

  logic final_blk;
  logic auto_cmd;
  logic io_read_gap;

  always_comb begin
    final_blk   = (cfg.len == LEN_SINGLE) || ((cfg.len == LEN_COUNTED) && cnt_last);
    auto_cmd    = (cfg.len == LEN_COUNTED) && !cfg.sdio && cfg.autostop;
    io_read_gap = cfg.sdio && cfg.rd;

    act      = ACT_NONE;
    idx      = cfg.sdio ? IDX_IO : IDX_MEM;
    set_hold = 1'b0;

    if (final_blk) begin
      act = auto_cmd ? ACT_COMMAND : ACT_FINISH;
      idx = IDX_MEM;
    end else if (stop_pend) begin
      act = ACT_COMMAND;
    end else if (gap_pend) begin
      if (io_read_gap) begin
        act      = ACT_COMMAND;
        idx      = IDX_IO;
        set_hold = cfg.rwait;
      end else begin
        act      = ACT_PARK_END;
        set_hold = 1'b1;
      end
    end
  end

endmodule

// File: rtl/transfer_stop_seq.sv
module transfer_stop_seq
  import tss_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             card_sdio,
  input  logic             dir_read,
  input  logic [1:0]       xfer_mode,
  input  logic [CNT_W-1:0] blk_count,
  input  logic             auto_stop,
  input  logic             read_wait_ok,
  input  logic             stop_req,
  input  logic             gap_req,
  input  logic             blk_done,
  input  logic             cmd_ready,
  output logic             cmd_valid,
  output logic [IDX_W-1:0] cmd_index,
  output logic             gap_hold,
  output logic             xfer_done
);

  localparam logic [CNT_W-1:0] ONE_BLK = {{(CNT_W-1){1'b0}}, 1'b1};

  seq_state_e       state_q;
  xfer_cfg_t        cfg_q;
  logic             launch;
  logic             in_xfer;
  logic             boundary;
  logic             handshake;
  logic             stop_pend;
  logic             gap_pend;
  logic             cnt_last;
  logic [CNT_W-1:0] load_val;
  bound_act_e       act;
  logic [IDX_W-1:0] sel_idx;
  logic             sel_hold;

  assign launch    = (state_q == ST_IDLE) && start;
  assign in_xfer   = (state_q == ST_XFER);
  assign boundary  = in_xfer && blk_done;
  assign handshake = (state_q == ST_ISSUE) && cmd_ready;
  assign load_val  = (len_class_e'(xfer_mode) == LEN_SINGLE) ? ONE_BLK : blk_count;

  tss_req_latch u_stop_latch (
    .clk     (clk),
    .rst     (rst),
    .enable  (in_xfer),
    .req     (stop_req),
    .clear   (launch | handshake),
    .pending (stop_pend)
  );

  tss_req_latch u_gap_latch (
    .clk     (clk),
    .rst     (rst),
    .enable  (in_xfer),
    .req     (gap_req),
    .clear   (launch | handshake),
    .pending (gap_pend)
  );

  tss_blk_counter #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .load     (launch),
    .load_val (load_val),
    .dec      (boundary),
    .at_last  (cnt_last)
  );

  tss_stop_select #(.IDX_W(IDX_W)) u_select (
    .cfg       (cfg_q),
    .cnt_last  (cnt_last),
    .stop_pend (stop_pend),
    .gap_pend  (gap_pend),
    .act       (act),
    .idx       (sel_idx),
    .set_hold  (sel_hold)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cfg_q     <= '0;
      cmd_valid <= 1'b0;
      cmd_index <= '0;
      gap_hold  <= 1'b0;
      xfer_done <= 1'b0;
    end else begin
      xfer_done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q        <= ST_XFER;
            cfg_q.sdio     <= card_sdio;
            cfg_q.rd       <= dir_read;
            cfg_q.len      <= len_class_e'(xfer_mode);
            cfg_q.autostop <= auto_stop;
            cfg_q.rwait    <= read_wait_ok;
            gap_hold       <= 1'b0;
          end
        end
        ST_XFER: begin
          if (blk_done) begin
            if (sel_hold) gap_hold <= 1'b1;
            unique case (act)
              ACT_FINISH, ACT_PARK_END: begin
                xfer_done <= 1'b1;
                state_q   <= ST_IDLE;
              end
              ACT_COMMAND: begin
                cmd_valid <= 1'b1;
                cmd_index <= sel_idx;
                state_q   <= ST_ISSUE;
              end
              default: ;
            endcase
          end
        end
        ST_ISSUE: begin
          if (cmd_ready) begin
            cmd_valid <= 1'b0;
            xfer_done <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tss_checker.sv
module tss_checker #(
  parameter int unsigned IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             blk_done,
  input logic             cmd_ready,
  input logic             cmd_valid,
  input logic [IDX_W-1:0] cmd_index,
  input logic             gap_hold,
  input logic             xfer_done
);

  // R11
  done_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done);

  // R11
  done_cmd_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(xfer_done && cmd_valid));

  // R6
  cmd_hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_index)));

  // R6
  cmd_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_valid) |-> $past(blk_done));

  // R7
  hold_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gap_hold) |-> $past(blk_done));

  // R3
  index_legal_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> ((cmd_index == IDX_W'(12)) || (cmd_index == IDX_W'(52))));

  // R2
  done_after_handshake_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> (xfer_done && !cmd_valid));

endmodule

bind transfer_stop_seq tss_checker #(.IDX_W(IDX_W)) u_tss_chk (
  .clk       (clk),
  .rst       (rst),
  .blk_done  (blk_done),
  .cmd_ready (cmd_ready),
  .cmd_valid (cmd_valid),
  .cmd_index (cmd_index),
  .gap_hold  (gap_hold),
  .xfer_done (xfer_done)
);

// File: tb/tb_transfer_stop_seq.sv
`timescale 1ns/1ps
module tb_transfer_stop_seq;

  localparam int CNT_W = 16;
  localparam int IDX_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 0, card_sdio = 0, dir_read = 0, auto_stop = 0, read_wait_ok = 0;
  logic [1:0] xfer_mode = 2'b00;
  logic [CNT_W-1:0] blk_count = '0;
  logic stop_req = 0, gap_req = 0, blk_done = 0, cmd_ready = 0;
  logic cmd_valid, gap_hold, xfer_done;
  logic [IDX_W-1:0] cmd_index;

  always #2.5 clk = ~clk;

  transfer_stop_seq #(.CNT_W(CNT_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst(rst), .start(start), .card_sdio(card_sdio), .dir_read(dir_read),
    .xfer_mode(xfer_mode), .blk_count(blk_count), .auto_stop(auto_stop),
    .read_wait_ok(read_wait_ok), .stop_req(stop_req), .gap_req(gap_req),
    .blk_done(blk_done), .cmd_ready(cmd_ready), .cmd_valid(cmd_valid),
    .cmd_index(cmd_index), .gap_hold(gap_hold), .xfer_done(xfer_done)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rdy_lat = 0;
  int rdy_wait = 0;
  string cur_req = "R12";

  // behavioural reference
  int m_st = 0;
  int m_mode = 0;
  int m_cnt = 1;
  int m_idx = 0;
  bit m_sdio, m_rd, m_auto, m_rw, m_ps, m_pg, m_cv, m_gap, m_done;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_st = 0; m_cv = 0; m_idx = 0; m_gap = 0; m_done = 0; m_ps = 0; m_pg = 0;
    end else begin
      m_done = 0;
      if (m_st == 0) begin
        if (start) begin
          m_st = 1; m_mode = xfer_mode; m_sdio = card_sdio; m_rd = dir_read;
          m_auto = auto_stop; m_rw = read_wait_ok; m_ps = 0; m_pg = 0; m_gap = 0;
          m_cnt = (xfer_mode == 0 || blk_count == 0) ? 1 : int'(blk_count);
        end
      end else if (m_st == 1) begin
        bit ps, pg;
        ps = m_ps || stop_req;
        pg = m_pg || gap_req;
        if (blk_done) begin
          if (m_mode == 0 || (m_mode == 1 && m_cnt <= 1)) begin
            if (m_mode == 1 && !m_sdio && m_auto) begin m_cv = 1; m_idx = 12; m_st = 2; end
            else begin m_done = 1; m_st = 0; end
          end else if (ps) begin
            m_cv = 1; m_idx = m_sdio ? 52 : 12; m_st = 2;
          end else if (pg) begin
            if (m_sdio && m_rd) begin m_cv = 1; m_idx = 52; m_gap = m_rw; m_st = 2; end
            else begin m_gap = 1; m_done = 1; m_st = 0; end
          end else m_cnt--;
        end
        m_ps = ps; m_pg = pg;
      end else begin
        if (cmd_ready) begin m_cv = 0; m_done = 1; m_st = 0; end
      end
    end
  end

  // per-cycle comparison, and a serializer that answers after rdy_lat cycles
  always @(negedge clk) begin
    if (cyc > 0) begin
      checks++;
      if (cmd_valid !== m_cv || cmd_index !== IDX_W'(m_idx) || gap_hold !== m_gap ||
          xfer_done !== m_done) begin
        fails++;
        $display("FAIL %s cyc %0d: actual valid=%b idx=%0d hold=%b done=%b expected valid=%b idx=%0d hold=%b done=%b",
                 cur_req, cyc, cmd_valid, cmd_index, gap_hold, xfer_done, m_cv, m_idx, m_gap, m_done);
      end
    end
    if (cmd_valid) begin
      cmd_ready <= (rdy_wait >= rdy_lat);
      rdy_wait++;
    end else begin
      cmd_ready <= 1'b0;
      rdy_wait = 0;
    end
    if (cyc >= 150000) begin
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic launch(input bit sd, input bit rd, input logic [1:0] md, input int n,
                        input bit au, input bit rw);
    @(negedge clk);
    start = 1; card_sdio = sd; dir_read = rd; xfer_mode = md;
    blk_count = CNT_W'(n); auto_stop = au; read_wait_ok = rw;
    @(negedge clk);
    start = 0;
  endtask

  task automatic boundary(input int gap_cycles);
    repeat (gap_cycles) @(negedge clk);
    blk_done = 1;
    @(negedge clk);
    blk_done = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_req = 1; @(negedge clk); stop_req = 0;
  endtask

  task automatic pulse_gap();
    @(negedge clk); gap_req = 1; @(negedge clk); gap_req = 0;
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    settle();

    cur_req = "R1";
    launch(0, 0, 2'b00, 5, 0, 0);
    boundary(4); settle();
    launch(1, 1, 2'b00, 0, 1, 1);
    pulse_stop(); boundary(2); settle();

    cur_req = "R9";
    pulse_stop(); pulse_gap(); settle();
    launch(0, 0, 2'b10, 0, 0, 0);
    boundary(3); boundary(3); settle();
    launch(1, 1, 2'b00, 0, 0, 0);
    boundary(2); settle();

    cur_req = "R2";
    rdy_lat = 3;
    launch(0, 1, 2'b10, 0, 0, 0);
    boundary(3); pulse_stop(); boundary(4); settle();
    rdy_lat = 0;
    launch(0, 0, 2'b01, 6, 1, 0);
    boundary(2); pulse_stop(); boundary(3); settle();

    cur_req = "R3";
    launch(1, 0, 2'b01, 8, 0, 0);
    boundary(2); pulse_stop(); boundary(2); settle();
    rdy_lat = 2;
    launch(1, 1, 2'b10, 0, 0, 0);
    pulse_stop(); boundary(3); settle();

    cur_req = "R4";
    rdy_lat = 1;
    launch(0, 0, 2'b01, 3, 1, 0);
    boundary(2); boundary(2); boundary(2); settle();
    launch(0, 1, 2'b01, 2, 0, 0);
    boundary(2); boundary(2); settle();
    launch(1, 1, 2'b01, 2, 1, 0);
    boundary(2); boundary(2); settle();

    cur_req = "R5";
    launch(0, 0, 2'b10, 1, 1, 0);
    for (int i = 0; i < 10; i++) boundary(2);
    pulse_stop(); boundary(2); settle();

    cur_req = "R6";
    launch(0, 0, 2'b10, 0, 0, 0);
    pulse_stop(); pulse_stop(); repeat (5) @(negedge clk);
    rdy_lat = 5;
    boundary(0); settle();
    rdy_lat = 0;

    cur_req = "R7";
    launch(0, 1, 2'b10, 0, 0, 0);
    boundary(2); pulse_gap(); boundary(3); settle();
    launch(1, 0, 2'b01, 9, 0, 1);
    pulse_gap(); boundary(2); settle();
    launch(0, 0, 2'b00, 0, 0, 0);
    boundary(2); settle();

    cur_req = "R8";
    launch(1, 1, 2'b10, 0, 0, 1);
    boundary(2); pulse_gap(); boundary(2); settle();
    launch(1, 1, 2'b01, 7, 0, 0);
    pulse_gap(); boundary(2); settle();

    cur_req = "R10";
    launch(0, 0, 2'b01, 2, 0, 0);
    boundary(2); pulse_stop(); boundary(2); settle();
    launch(1, 0, 2'b10, 0, 0, 0);
    @(negedge clk); stop_req = 1; gap_req = 1; @(negedge clk); stop_req = 0; gap_req = 0;
    boundary(2); settle();
    launch(0, 1, 2'b00, 0, 0, 0);
    pulse_gap(); boundary(1); settle();

    cur_req = "R11";
    launch(1, 0, 2'b01, 3, 0, 0);
    boundary(1); boundary(1); boundary(1); settle();

    cur_req = "R12";
    rst = 1; repeat (3) @(negedge clk); rst = 0; settle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule